// File: doc/BRIEF.md
# Wake-up header detector

This block watches a demodulated bit stream for a wake-up frame while the rest of the receiver sleeps. A periodic base tick starts each attempt. The attempt goes ahead only when the received-signal-strength flag is high. The block then compares the incoming bits, one per bit strobe, against a programmable address header, and it gives up on the first bit that differs. After a full header match it captures a data field. The field length is either a programmed constant or a 5-bit count that arrives in the stream ahead of the data. When the field is complete, the block raises a sticky wake flag.

A 3-bit window code limits how long a header search may run, counted in base ticks. The code maps to a multiple of the base period that grows faster than linearly. Code 0 instead selects a mode in which signal strength must stay high for the whole header. An optional rate check compares the spacing of header bit strobes against an expected bit period, with a tolerance. The rate is counted in clock cycles, so a 640 kHz measurement clock gives a rate of 640000 divided by the bit rate.

Top module: `wkup_detect`

## Requirements
- R1: After reset, wake_o is 0, data_o is 0 and rx_len_o is 0.
- R2: A base tick while idle starts a header search only if rssi_ok_i is high in that cycle. A tick while rssi_ok_i is low has no effect, and the bits that follow are ignored.
- R3: The header bits are compared against addr_i in order. The first bit strobe is compared with bit L-1 of addr_i and the last with bit 0, where L is addr_len_i. A value of 0 is treated as 1 and values above 20 are treated as 20. At the first mismatch the detector goes idle, and further bits are ignored until the next qualifying tick.
- R4: A window code c in 1..7 allows n base ticks, with n = 1, 2, 3, 4, 8, 16, 31 for c = 1..7. The header must complete before the n-th tick that arrives after the starting tick, otherwise the search is dropped.
- R5: With window code 0, ticks during the header are ignored. The search is dropped in any header cycle where rssi_ok_i is low.
- R6: When rate_chk_i is 1, each header bit after the first must arrive between rate_i - rate_tol_i and rate_i + rate_tol_i clock cycles (inclusive) after the previous strobe, otherwise the search is dropped. When rate_chk_i is 0, the spacing has no effect.
- R7: In fixed mode (var_len_i = 0), exactly data_len_i data bits follow the header. A data_len_i of 0 completes the frame on the last header bit, with data 0 and length 0.
- R8: In variable mode (var_len_i = 1), a 5-bit length arrives first, least significant bit first, and that many data bits follow. A received length of 0 completes the frame at once.
- R9: Data bit k (counting from 0 in arrival order) is stored in data_o[k], and all higher bits of data_o are 0.
- R10: data_o and rx_len_o change only when a frame completes. They take their new values in the same cycle that wake_o sets, one clock after the strobe of the final bit, and otherwise hold.
- R11: wake_o stays at 1 until flag_clr_i is sampled high. If a frame completes in the same cycle as a clear, wake_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the rate measurement time base |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_valid_i | input | 1 | One-cycle strobe marking a received bit |
| bit_i | input | 1 | Received bit value, valid with the strobe |
| rssi_ok_i | input | 1 | Signal strength above threshold |
| base_tick_i | input | 1 | One-cycle pulse of the base check period |
| wl2_code_i | input | 3 | Header window code |
| addr_i | input | 20 | Expected address header |
| addr_len_i | input | 5 | Header length in bits |
| var_len_i | input | 1 | 1: length taken from the stream; 0: fixed length |
| data_len_i | input | 5 | Fixed data length in bits |
| rate_i | input | 10 | Expected bit period in clock cycles |
| rate_tol_i | input | 5 | Allowed deviation of the bit period |
| rate_chk_i | input | 1 | Enable the bit rate check |
| flag_clr_i | input | 1 | Clears the wake flag (read side effect) |
| wake_o | output | 1 | Sticky wake-up flag |
| data_o | output | 32 | Captured data, first bit in bit 0 |
| rx_len_o | output | 5 | Number of data bits in the last frame |

## Verification
The completion of a frame and a clear of the wake flag can land on the same clock edge. This happens when flag_clr_i is held high in exactly the cycle that carries the strobe of the final data bit. The bench provokes this by driving both on the same negative edge while the flag is already set from an earlier frame. It judges the result by requiring wake_o to still read 1, with data_o and rx_len_o showing the new frame. A companion check just before it confirms that the outputs still hold the previous frame while the new one is only half received.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_HDR,
    S_LEN,
    S_DATA
  } wk_state_e;

  localparam int WIN_W = 5;

  // window code -> number of base periods; 0 = no limit (rssi held instead)
  function automatic logic [WIN_W-1:0] win_mult(input logic [2:0] code);
    case (code)
      3'd0:    win_mult = 5'd0;
      3'd1:    win_mult = 5'd1;
      3'd2:    win_mult = 5'd2;
      3'd3:    win_mult = 5'd3;
      3'd4:    win_mult = 5'd4;
      3'd5:    win_mult = 5'd8;
      3'd6:    win_mult = 5'd16;
      default: win_mult = 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/wkup_window.sv
module wkup_window
  import wkup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       active_i,
  input  logic       tick_i,
  input  logic [2:0] code_i,
  output logic       timeout_o,
  output logic       rssi_hold_o
);

  logic [WIN_W-1:0] rem_q;
  logic             unlim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      unlim_q <= 1'b1;
    end else if (start_i) begin
      rem_q   <= win_mult(code_i);
      unlim_q <= (code_i == 3'd0);
    end else if (active_i && tick_i && !unlim_q && rem_q != WIN_W'(1)) begin
      rem_q <= rem_q - WIN_W'(1);
    end
  end

  assign timeout_o   = active_i && tick_i && !unlim_q && (rem_q == WIN_W'(1));
  assign rssi_hold_o = unlim_q;

  AST_WIN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !unlim_q) |-> (rem_q != '0)); // R4

endmodule

// File: rtl/wkup_rate.sv
module wkup_rate #(
  parameter int RW = 10,
  parameter int TW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_valid_i,
  input  logic [RW-1:0] rate_i,
  input  logic [TW-1:0] tol_i,
  output logic          rate_ok_o
);

  localparam int GW = RW + 1;
  localparam logic [GW-1:0] GMAX = '1;

  logic [GW-1:0] gap_q;
  logic [GW:0]   gap_x, rate_x, diff;

  // cycles since the previous strobe, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               gap_q <= '0;
    else if (bit_valid_i)      gap_q <= GW'(1);
    else if (gap_q != GMAX)    gap_q <= gap_q + GW'(1);
  end

  always_comb begin
    gap_x  = {1'b0, gap_q};
    rate_x = (GW+1)'(rate_i);
    diff   = (gap_x >= rate_x) ? (gap_x - rate_x) : (rate_x - gap_x);
  end

  assign rate_ok_o = (diff <= (GW+1)'(tol_i));

  AST_GAP_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_i |=> (gap_q == GW'(1))); // R6

endmodule

// File: rtl/wkup_capture.sv
module wkup_capture #(
  parameter int LW = 5,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic          bit_i,
  input  logic [LW-1:0] idx_i,
  input  logic          latch_i,
  input  logic [LW-1:0] len_i,
  output logic [DW-1:0] data_o,
  output logic [LW-1:0] len_o
);

  logic [DW-1:0] cap_q, cap_d;

  always_comb begin
    cap_d = cap_q;
    if (clr_i)        cap_d = '0;
    else if (shift_i) cap_d[idx_i] = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      data_o <= '0;
      len_o  <= '0;
    end else begin
      cap_q <= cap_d;
      if (latch_i) begin
        data_o <= cap_d;
        len_o  <= len_i;
      end
    end
  end

  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> ($stable(data_o) && $stable(len_o))); // R10

endmodule

// File: rtl/wkup_detect.sv
module wkup_detect
  import wkup_pkg::*;
#(
  parameter int AW = 20,
  parameter int LW = 5,
  parameter int RW = 10,
  parameter int TW = 5,
  localparam int AIW = $clog2(AW + 1),
  localparam int DW  = 2 ** LW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bit_valid_i,
  input  logic           bit_i,
  input  logic           rssi_ok_i,
  input  logic           base_tick_i,
  input  logic [2:0]     wl2_code_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [AIW-1:0] addr_len_i,
  input  logic           var_len_i,
  input  logic [LW-1:0]  data_len_i,
  input  logic [RW-1:0]  rate_i,
  input  logic [TW-1:0]  rate_tol_i,
  input  logic           rate_chk_i,
  input  logic           flag_clr_i,
  output logic           wake_o,
  output logic [DW-1:0]  data_o,
  output logic [LW-1:0]  rx_len_o
);

  localparam int AXW = $clog2(AW);
  localparam int LXW = $clog2(LW);
  localparam int IW  = (AXW > LW) ? AXW : LW;

  wk_state_e     state_q, state_d;
  logic [IW-1:0] idx_q, idx_d, alen_m1;
  logic [LW-1:0] len_q, len_d, len_new;
  logic          first_q, first_d;
  logic          start, cap_clr, shift, done;
  logic          timeout, rssi_hold, rate_ok, hdr_bad;
  logic          wake_q;

  wkup_window u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .active_i    (state_q == S_HDR),
    .tick_i      (base_tick_i),
    .code_i      (wl2_code_i),
    .timeout_o   (timeout),
    .rssi_hold_o (rssi_hold)
  );

  wkup_rate #(.RW(RW), .TW(TW)) u_rate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_valid_i (bit_valid_i),
    .rate_i      (rate_i),
    .tol_i       (rate_tol_i),
    .rate_ok_o   (rate_ok)
  );

  wkup_capture #(.LW(LW), .DW(DW)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cap_clr),
    .shift_i (shift),
    .bit_i   (bit_i),
    .idx_i   (idx_q[LW-1:0]),
    .latch_i (done),
    .len_i   (len_d),
    .data_o  (data_o),
    .len_o   (rx_len_o)
  );

  // header length clipped to 1..AW
  always_comb begin
    if (addr_len_i == '0)           alen_m1 = '0;
    else if (addr_len_i > AIW'(AW)) alen_m1 = IW'(AW - 1);
    else                            alen_m1 = IW'(addr_len_i) - IW'(1);
  end

  always_comb begin
    hdr_bad = (bit_i != addr_i[idx_q[AXW-1:0]]) ||
              (rate_chk_i && !first_q && !rate_ok);
    len_new = len_q;
    len_new[idx_q[LXW-1:0]] = bit_i;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    len_d   = len_q;
    first_d = first_q;
    start   = 1'b0;
    cap_clr = 1'b0;
    shift   = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (base_tick_i && rssi_ok_i) begin
          state_d = S_HDR;
          idx_d   = alen_m1;
          first_d = 1'b1;
          start   = 1'b1;
        end
      end
      S_HDR: begin
        if (timeout || (rssi_hold && !rssi_ok_i)) begin
          state_d = S_IDLE;
        end else if (bit_valid_i) begin
          first_d = 1'b0;
          if (hdr_bad) begin
            state_d = S_IDLE;
          end else if (idx_q == '0) begin
            cap_clr = 1'b1;
            idx_d   = '0;
            if (var_len_i) begin
              state_d = S_LEN;
              len_d   = '0;
            end else if (data_len_i == '0) begin
              state_d = S_IDLE;
              len_d   = '0;
              done    = 1'b1;
            end else begin
              state_d = S_DATA;
              len_d   = data_len_i;
            end
          end else begin
            idx_d = idx_q - IW'(1);
          end
        end
      end
      S_LEN: begin
        if (bit_valid_i) begin
          len_d = len_new;
          if (idx_q == IW'(LW - 1)) begin
            idx_d = '0;
            if (len_new == '0) begin
              state_d = S_IDLE;
              done    = 1'b1;
            end else begin
              state_d = S_DATA;
            end
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      S_DATA: begin
        if (bit_valid_i) begin
          shift = 1'b1;
          if (idx_q == IW'(len_q) - IW'(1)) begin
            state_d = S_IDLE;
            done    = 1'b1;
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      first_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      first_q <= first_d;
      // completion outranks a clear in the same cycle
      if (done)            wake_q <= 1'b1;
      else if (flag_clr_i) wake_q <= 1'b0;
    end
  end

  assign wake_o = wake_q;

  AST_WAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !flag_clr_i) |=> wake_o); // R11

  AST_RSSI_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HDR && rssi_hold && !rssi_ok_i) |=> (state_q == S_IDLE)); // R5

  AST_WIN_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout |=> (state_q == S_IDLE)); // R4

  AST_RISE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_o && !$stable(rx_len_o)) |-> wake_o); // R10

endmodule

// File: tb/sim_wkup_detect.sv
module sim_wkup_detect;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0, bit_v = 1'b0, rssi = 1'b1, tick = 1'b0;
  logic [2:0]  code = 3'd1;
  logic [19:0] addr = 20'h0F0F0;
  logic [4:0]  alen = 5'd9;
  logic        var_len = 1'b0;
  logic [4:0]  dlen = 5'd8;
  logic [9:0]  rate = 10'd20;
  logic [4:0]  tol = 5'd2;
  logic        rchk = 1'b0;
  logic        fclr = 1'b0;
  logic        wake;
  logic [31:0] data;
  logic [4:0]  rlen;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic        wake;
    logic [31:0] data;
    logic [4:0]  len;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  wkup_detect u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bit_valid_i (bit_valid),
    .bit_i       (bit_v),
    .rssi_ok_i   (rssi),
    .base_tick_i (tick),
    .wl2_code_i  (code),
    .addr_i      (addr),
    .addr_len_i  (alen),
    .var_len_i   (var_len),
    .data_len_i  (dlen),
    .rate_i      (rate),
    .rate_tol_i  (tol),
    .rate_chk_i  (rchk),
    .flag_clr_i  (fclr),
    .wake_o      (wake),
    .data_o      (data),
    .rx_len_o    (rlen)
  );

  // monitor: compares queued expectations against the ports
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        total += 3;
        if (wake !== it.wake) begin
          bad++;
          $display("FAIL %s: wake actual=%0h expected=%0h", it.tag, wake, it.wake);
        end
        if (data !== it.data) begin
          bad++;
          $display("FAIL %s: data actual=%0h expected=%0h", it.tag, data, it.data);
        end
        if (rlen !== it.len) begin
          bad++;
          $display("FAIL %s: len actual=%0d expected=%0d", it.tag, rlen, it.len);
        end
      end
    end
  end

  task automatic expect_out(input logic w, input logic [31:0] d, input logic [4:0] l,
                            input string tag);
    exp_t it;
    it.wake = w; it.data = d; it.len = l; it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic send_bit(input logic b, input int gap, input logic with_clr);
    bit_v = b;
    bit_valid = 1'b1;
    fclr = with_clr;
    @(negedge clk);
    bit_valid = 1'b0;
    fclr = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [19:0] a, input int hi, input int lo, input int gap);
    for (int i = hi; i >= lo; i--) send_bit(a[i], gap, 1'b0);
  endtask

  task automatic send_data(input logic [31:0] v, input int n, input int gap);
    for (int i = 0; i < n; i++) send_bit(v[i], gap, 1'b0);
  endtask

  task automatic clear_flag();
    fclr = 1'b1;
    @(negedge clk);
    fclr = 1'b0;
  endtask

  task automatic fixed_frame(input logic [31:0] v);
    do_tick(1);
    send_hdr(addr, 8, 0, 20);
    send_data(v, 8, 20);
  endtask

  // split header with n ticks in the middle
  task automatic window_frame(input logic [2:0] c, input int n, input logic [31:0] v);
    code = c;
    do_tick(1);
    send_hdr(addr, 8, 4, 20);
    do_tick(n);
    send_hdr(addr, 3, 0, 20);
    send_data(v, 8, 20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(1'b0, 32'h0, 5'd0, "R1 reset");

    fixed_frame(32'hA5);
    expect_out(1'b1, 32'hA5, 5'd8, "R7 R9 fixed frame");
    clear_flag();
    expect_out(1'b0, 32'hA5, 5'd8, "R11 clear, R10 hold");

    rssi = 1'b0;
    do_tick(1);
    rssi = 1'b1;
    send_hdr(addr, 8, 0, 20);
    send_data(32'h3C, 8, 20);
    expect_out(1'b0, 32'hA5, 5'd8, "R2 low rssi tick");

    do_tick(1);
    send_hdr(addr ^ 20'h00020, 8, 0, 20);
    send_data(32'h3C, 8, 20);
    expect_out(1'b0, 32'hA5, 5'd8, "R3 header mismatch");

    addr = 20'hB3C5A; alen = 5'd20; dlen = 5'd0;
    do_tick(1);
    send_hdr(addr, 19, 0, 20);
    expect_out(1'b1, 32'h0, 5'd0, "R3 R7 20-bit header, zero length");
    clear_flag();

    alen = 5'd31;
    do_tick(1);
    send_hdr(addr, 19, 0, 20);
    expect_out(1'b1, 32'h0, 5'd0, "R3 length clipped to 20");
    clear_flag();

    addr = 20'h0F0F0; alen = 5'd9; var_len = 1'b1;
    do_tick(1);
    send_hdr(addr, 8, 0, 20);
    send_data(32'd12, 5, 20);
    send_data(32'hABC, 12, 20);
    expect_out(1'b1, 32'hABC, 5'd12, "R8 R9 variable length");
    clear_flag();

    do_tick(1);
    send_hdr(addr, 8, 0, 20);
    send_data(32'd0, 5, 20);
    expect_out(1'b1, 32'h0, 5'd0, "R8 received length zero");
    clear_flag();
    var_len = 1'b0; dlen = 5'd8;

    window_frame(3'd1, 1, 32'h3C);
    expect_out(1'b0, 32'h0, 5'd0, "R4 code 1 expires");
    window_frame(3'd4, 4, 32'h3C);
    expect_out(1'b0, 32'h0, 5'd0, "R4 code 4 expires");
    window_frame(3'd4, 3, 32'h3C);
    expect_out(1'b1, 32'h3C, 5'd8, "R4 code 4 in window");
    clear_flag();
    window_frame(3'd5, 7, 32'h11);
    expect_out(1'b1, 32'h11, 5'd8, "R4 code 5 in window");
    clear_flag();
    window_frame(3'd5, 8, 32'h3C);
    expect_out(1'b0, 32'h11, 5'd8, "R4 code 5 expires");
    window_frame(3'd7, 30, 32'h22);
    expect_out(1'b1, 32'h22, 5'd8, "R4 code 7 in window");
    clear_flag();
    window_frame(3'd6, 16, 32'h3C);
    expect_out(1'b0, 32'h22, 5'd8, "R4 code 6 expires");

    window_frame(3'd0, 5, 32'h44);
    expect_out(1'b1, 32'h44, 5'd8, "R5 code 0 ignores ticks");
    clear_flag();
    code = 3'd0;
    do_tick(1);
    send_hdr(addr, 8, 4, 20);
    rssi = 1'b0;
    repeat (3) @(negedge clk);
    rssi = 1'b1;
    send_hdr(addr, 3, 0, 20);
    send_data(32'h3C, 8, 20);
    expect_out(1'b0, 32'h44, 5'd8, "R5 rssi drop aborts");

    code = 3'd1; rchk = 1'b1;
    do_tick(1);
    send_hdr(addr, 8, 0, 23);
    send_data(32'h3C, 8, 23);
    expect_out(1'b0, 32'h44, 5'd8, "R6 slow by tol+1");
    do_tick(1);
    send_hdr(addr, 8, 0, 17);
    send_data(32'h3C, 8, 17);
    expect_out(1'b0, 32'h44, 5'd8, "R6 fast by tol+1");
    do_tick(1);
    send_hdr(addr, 8, 0, 22);
    send_data(32'h55, 8, 22);
    expect_out(1'b1, 32'h55, 5'd8, "R6 at tolerance edge");
    clear_flag();
    rchk = 1'b0;
    do_tick(1);
    send_hdr(addr, 8, 0, 30);
    send_data(32'h66, 8, 30);
    expect_out(1'b1, 32'h66, 5'd8, "R6 check disabled");
    clear_flag();

    fixed_frame(32'h77);
    expect_out(1'b1, 32'h77, 5'd8, "R7 second fixed frame");
    do_tick(1);
    send_hdr(addr, 8, 0, 20);
    send_data(32'h88, 4, 20);
    expect_out(1'b1, 32'h77, 5'd8, "R10 outputs held mid frame");
    send_data(32'h08, 3, 20);
    send_bit(1'b1, 20, 1'b1);
    expect_out(1'b1, 32'h88, 5'd8, "R11 set wins over clear");
    clear_flag();
    expect_out(1'b0, 32'h88, 5'd8, "R11 cleared");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule